// File: doc/BRIEF.md
# Scheduled Time Event Generator

This block keeps its own time-of-day count, a 64-bit number of 10 ns ticks that advances once per cycle of a 100 MHz clock. Software may overwrite the count outright or shift it by a signed offset. From that count the block drives one digital line toward a signal router, in one of two ways: a one-shot event that moves the line to a chosen level once the time reaches a programmed target, or a generated clock that runs between an absolute start time and an absolute stop time, with high and low phases each set in whole ticks.

Everything is programmed through a small write-only register port: a write strobe, a 3-bit register select and a 64-bit data word. All time comparisons are greater-than-or-equal, so a target that is already behind the current time takes effect at once rather than being missed. Front-panel consumers of the line are expected to keep generated clocks at or below about 1.5 MHz; the block itself does not limit the phase lengths beyond their lower bound of one tick.

Top module: `sched_event_gen`

## Requirements
- R1: The time count is zero in reset and then grows by exactly one per clock cycle, wrapping from all-ones to zero, when no load or shift write is made; it is visible on `tod`.
- R2: A write to select 0 replaces the time count with the data word; `tod` shows that value in the cycle after the write.
- R3: A write to select 1 treats the data word as a signed offset: the next count is the current count plus one plus the offset, modulo 2^64.
- R4: A write to select 5 carries the high phase in bits 23:0 and the low phase in bits 47:24, both in ticks. If either field is zero the write is discarded, the previous phases stay in force and `cfg_error` goes high; a write with both fields non-zero stores them and clears `cfg_error`.
- R5: Select 2 holds the one-shot target. A write to select 6 with bits 1:0 = 1 arms the one-shot, bit 2 giving the level; `evt_armed` rises in the next cycle, and one cycle after the count is first seen at or above the target `evt_out` takes the level and `evt_armed` falls.
- R6: A one-shot target that is already at or below the count when armed fires at the first comparison after arming.
- R7: After a one-shot fires or is cancelled, `evt_out` keeps its value whatever happens to the count or the target until the block is armed again.
- R8: Selects 3 and 4 hold the clock start and stop times. A write to select 6 with bits 1:0 = 2 arms the clock: `evt_out` goes low, then once the count reaches the start time (or at once if it already has) it goes high for the high phase, low for the low phase, and repeats.
- R9: When the count reaches the stop time the clock line goes low and `evt_armed` falls, even in the middle of a high phase and even if the clock never started.
- R10: A write to select 6 with bits 1:0 = 0 cancels whatever is armed; a cancelled clock drives `evt_out` low, a cancelled one-shot keeps its level. Arming either kind cancels the other.
- R11: In reset `evt_out`, `evt_armed` and `cfg_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 64 | Register write data |
| evt_out | output | 1 | Scheduled event or generated clock line to the router |
| evt_armed | output | 1 | High while a one-shot or clock is pending or running |
| cfg_error | output | 1 | Last phase-length write was rejected |
| tod | output | 64 | Current time-of-day count in ticks |

## Verification
The assertions assume that the register port makes at most one write per cycle, so a load or shift of the count never coincides with a command, and that time is monotonic between software writes, which is what makes a single greater-than-or-equal comparison a valid trigger. The stimulus keeps targets, start and stop times a few hundred ticks from a count loaded near 1000, so no scheduled run straddles the 64-bit wrap; the wrap itself is exercised alone. Phase lengths are drawn small so many full periods fit before the stop time, and start offsets include zero so the already-late start path is reached.

// File: rtl/sched_pkg.sv
package sched_pkg;

    parameter int TIME_W_DEF = 64;
    parameter int HALF_W_DEF = 24;
    parameter int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        REG_TOD_LOAD  = 3'd0,
        REG_TOD_STEP  = 3'd1,
        REG_SHOT_AT   = 3'd2,
        REG_CLK_START = 3'd3,
        REG_CLK_STOP  = 3'd4,
        REG_HALVES    = 3'd5,
        REG_COMMAND   = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_DISARM = 2'd0,
        CMD_SHOT   = 2'd1,
        CMD_CLK    = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_SHOT = 2'd1,
        MODE_CLK  = 2'd2
    } out_mode_e;

endpackage

// File: rtl/sched_tod.sv
module sched_tod #(
    parameter int TIME_W = sched_pkg::TIME_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [TIME_W-1:0] wval,
    output logic [TIME_W-1:0] tod_q
);

    typedef struct packed {
        logic [TIME_W-1:0] tod;
    } tod_st_t;

    tod_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.tod = wval;
        end else if (step) begin
            st_d.tod = st_q.tod + TIME_W'(1) + wval;
        end else begin
            st_d.tod = st_q.tod + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tod_q = st_q.tod;

    // R1: free-running advance
    p_tod_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> (tod_q == $past(tod_q) + TIME_W'(1)));

    // R2: load takes the written value
    p_tod_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tod_q == $past(wval)));

endmodule

// File: rtl/sched_cfg.sv
module sched_cfg
    import sched_pkg::*;
#(
    parameter int TIME_W = TIME_W_DEF,
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [TIME_W-1:0] cfg_wdata,
    output logic              tod_load,
    output logic              tod_step,
    output logic              arm_shot,
    output logic              arm_clk,
    output logic              disarm,
    output logic [TIME_W-1:0] shot_at,
    output logic              shot_level,
    output logic [TIME_W-1:0] clk_start,
    output logic [TIME_W-1:0] clk_stop,
    output logic [HALF_W-1:0] half_hi,
    output logic [HALF_W-1:0] half_lo,
    output out_mode_e         mode,
    output logic              cfg_error
);

    localparam int HALVES_W = 2 * HALF_W;

    typedef struct packed {
        logic [TIME_W-1:0] shot_at;
        logic [TIME_W-1:0] clk_start;
        logic [TIME_W-1:0] clk_stop;
        logic [HALF_W-1:0] half_hi;
        logic [HALF_W-1:0] half_lo;
        logic              shot_level;
        logic              cfg_error;
        out_mode_e         mode;
    } cfg_st_t;

    localparam cfg_st_t CFG_RST = '{
        shot_at:    '0,
        clk_start:  '0,
        clk_stop:   '0,
        half_hi:    HALF_W'(1),
        half_lo:    HALF_W'(1),
        shot_level: 1'b0,
        cfg_error:  1'b0,
        mode:       MODE_IDLE
    };

    cfg_st_t st_d, st_q;

    reg_sel_e          sel;
    cmd_e              cmd;
    logic [HALF_W-1:0] wr_hi;
    logic [HALF_W-1:0] wr_lo;
    logic [HALVES_W-1:0] wr_halves;

    assign sel       = reg_sel_e'(cfg_addr);
    assign cmd       = cmd_e'(cfg_wdata[1:0]);
    assign wr_halves = cfg_wdata[HALVES_W-1:0];
    assign wr_hi     = wr_halves[HALF_W-1:0];
    assign wr_lo     = wr_halves[HALVES_W-1:HALF_W];

    always_comb begin
        st_d     = st_q;
        tod_load = 1'b0;
        tod_step = 1'b0;
        arm_shot = 1'b0;
        arm_clk  = 1'b0;
        disarm   = 1'b0;
        if (cfg_we) begin
            case (sel)
                REG_TOD_LOAD:  tod_load = 1'b1;
                REG_TOD_STEP:  tod_step = 1'b1;
                REG_SHOT_AT:   st_d.shot_at   = cfg_wdata;
                REG_CLK_START: st_d.clk_start = cfg_wdata;
                REG_CLK_STOP:  st_d.clk_stop  = cfg_wdata;
                REG_HALVES: begin
                    if ((wr_hi == '0) || (wr_lo == '0)) begin
                        st_d.cfg_error = 1'b1;
                    end else begin
                        st_d.half_hi   = wr_hi;
                        st_d.half_lo   = wr_lo;
                        st_d.cfg_error = 1'b0;
                    end
                end
                REG_COMMAND: begin
                    case (cmd)
                        CMD_DISARM: disarm = 1'b1;
                        CMD_SHOT: begin
                            arm_shot        = 1'b1;
                            st_d.mode       = MODE_SHOT;
                            st_d.shot_level = cfg_wdata[2];
                        end
                        CMD_CLK: begin
                            arm_clk   = 1'b1;
                            st_d.mode = MODE_CLK;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign shot_at    = st_q.shot_at;
    assign shot_level = st_q.shot_level;
    assign clk_start  = st_q.clk_start;
    assign clk_stop   = st_q.clk_stop;
    assign half_hi    = st_q.half_hi;
    assign half_lo    = st_q.half_lo;
    assign mode       = st_q.mode;
    assign cfg_error  = st_q.cfg_error;

    // R4: a zero phase field raises the error flag and leaves phases alone
    p_zero_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (sel == REG_HALVES) && ((wr_hi == '0) || (wr_lo == '0)))
        |=> (cfg_error && $stable(half_hi) && $stable(half_lo)));

    // R4: stored phases are never zero
    p_half_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (half_hi != '0) && (half_lo != '0));

endmodule

// File: rtl/sched_oneshot.sv
module sched_oneshot #(
    parameter int TIME_W = sched_pkg::TIME_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              disarm,
    input  logic              level,
    input  logic [TIME_W-1:0] target,
    input  logic [TIME_W-1:0] tod,
    output logic              armed_q,
    output logic              out_q
);

    typedef struct packed {
        logic armed;
        logic out;
    } shot_st_t;

    shot_st_t st_d, st_q;
    logic     due;

    assign due = (tod >= target);

    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d.armed = 1'b1;
        end else if (disarm) begin
            st_d.armed = 1'b0;
        end else if (st_q.armed && due) begin
            st_d.armed = 1'b0;
            st_d.out   = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_q = st_q.armed;
    assign out_q   = st_q.out;

    // R5: an armed shot that comes due takes its level and disarms
    p_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !arm && !disarm && (tod >= target))
        |=> (!armed_q && (out_q == $past(level))));

    // R7: an idle shot holds its output
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !arm) |=> $stable(out_q));

endmodule

// File: rtl/sched_clkgen.sv
module sched_clkgen #(
    parameter int TIME_W = sched_pkg::TIME_W_DEF,
    parameter int HALF_W = sched_pkg::HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              disarm,
    input  logic [TIME_W-1:0] start_at,
    input  logic [TIME_W-1:0] stop_at,
    input  logic [HALF_W-1:0] half_hi,
    input  logic [HALF_W-1:0] half_lo,
    input  logic [TIME_W-1:0] tod,
    output logic              armed_q,
    output logic              out_q
);

    typedef struct packed {
        logic              armed;
        logic              running;
        logic              out;
        logic [HALF_W-1:0] left;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    past_stop;
    logic    past_start;

    assign past_stop  = (tod >= stop_at);
    assign past_start = (tod >= start_at);

    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d = '{armed: 1'b1, running: 1'b0, out: 1'b0, left: '0};
        end else if (disarm) begin
            st_d.armed   = 1'b0;
            st_d.running = 1'b0;
            st_d.out     = 1'b0;
        end else if (st_q.armed) begin
            if (past_stop) begin
                st_d.armed   = 1'b0;
                st_d.running = 1'b0;
                st_d.out     = 1'b0;
            end else if (!st_q.running) begin
                if (past_start) begin
                    st_d.running = 1'b1;
                    st_d.out     = 1'b1;
                    st_d.left    = half_hi;
                end
            end else if (st_q.left == HALF_W'(1)) begin
                st_d.out  = ~st_q.out;
                st_d.left = st_q.out ? half_lo : half_hi;
            end else begin
                st_d.left = st_q.left - HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_q = st_q.armed;
    assign out_q   = st_q.out;

    // R9: reaching the stop time forces the line low and disarms
    p_stop_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !arm && !disarm && (tod >= stop_at))
        |=> (!out_q && !armed_q));

    // R8: reaching the start time raises the line
    p_start_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !st_q.running && !arm && !disarm
         && (tod < stop_at) && (tod >= start_at))
        |=> out_q);

    // R10: a cancelled clock is low
    p_disarm_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && !arm) |=> (!out_q && !armed_q));

endmodule

// File: rtl/sched_event_gen.sv
module sched_event_gen
    import sched_pkg::*;
#(
    parameter int TIME_W = TIME_W_DEF,
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [TIME_W-1:0] cfg_wdata,
    output logic              evt_out,
    output logic              evt_armed,
    output logic              cfg_error,
    output logic [TIME_W-1:0] tod
);

    logic              tod_load, tod_step;
    logic              arm_shot, arm_clk, disarm;
    logic [TIME_W-1:0] shot_at, clk_start, clk_stop;
    logic              shot_level;
    logic [HALF_W-1:0] half_hi, half_lo;
    out_mode_e         mode;
    logic              shot_armed, shot_out;
    logic              gen_armed, gen_out;

    sched_tod #(.TIME_W(TIME_W)) u_tod (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tod_load),
        .step  (tod_step),
        .wval  (cfg_wdata),
        .tod_q (tod)
    );

    sched_cfg #(.TIME_W(TIME_W), .HALF_W(HALF_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .tod_load   (tod_load),
        .tod_step   (tod_step),
        .arm_shot   (arm_shot),
        .arm_clk    (arm_clk),
        .disarm     (disarm),
        .shot_at    (shot_at),
        .shot_level (shot_level),
        .clk_start  (clk_start),
        .clk_stop   (clk_stop),
        .half_hi    (half_hi),
        .half_lo    (half_lo),
        .mode       (mode),
        .cfg_error  (cfg_error)
    );

    sched_oneshot #(.TIME_W(TIME_W)) u_shot (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm_shot),
        .disarm  (disarm | arm_clk),
        .level   (shot_level),
        .target  (shot_at),
        .tod     (tod),
        .armed_q (shot_armed),
        .out_q   (shot_out)
    );

    sched_clkgen #(.TIME_W(TIME_W), .HALF_W(HALF_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_clk),
        .disarm   (disarm | arm_shot),
        .start_at (clk_start),
        .stop_at  (clk_stop),
        .half_hi  (half_hi),
        .half_lo  (half_lo),
        .tod      (tod),
        .armed_q  (gen_armed),
        .out_q    (gen_out)
    );

    always_comb begin
        case (mode)
            MODE_SHOT: evt_out = shot_out;
            MODE_CLK:  evt_out = gen_out;
            default:   evt_out = 1'b0;
        endcase
    end

    assign evt_armed = shot_armed | gen_armed;

    // R10: arming either kind cancels the other
    p_one_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(shot_armed && gen_armed));

    // R11: idle after reset until a command arrives
    p_reset_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |-> (!evt_out && !evt_armed));

endmodule

// File: tb/sched_event_gen_test.sv
module sched_event_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        evt_out, evt_armed, cfg_error;
    logic [63:0] tod;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] tod_at_wr;
    logic        exp_shot_out = 1'b0;
    int unsigned cur_hi = 1;
    int unsigned cur_lo = 1;

    sched_event_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .evt_out   (evt_out),
        .evt_armed (evt_armed),
        .cfg_error (cfg_error),
        .tod       (tod)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        tod_at_wr = tod;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic logic clk_expect(input longint unsigned c, input longint unsigned s,
                                        input int unsigned h, input int unsigned l);
        longint unsigned ph;
        ph = (c - s) % longint'(h + l);
        return (ph < longint'(h));
    endfunction

    // one-shot run; offset relative to the count at arming
    task automatic run_shot(input int off, input logic lvl);
        logic [63:0] target;
        logic        fired = 1'b0;
        int          after = 0;
        target = tod + 64'(signed'(longint'(off))) + 64'd2;
        wr(3'd2, target);
        wr(3'd6, {61'd0, lvl, 2'd1});
        chk("R5 armed after arm", {63'd0, evt_armed}, 64'd1);
        chk("R5 level before fire", {63'd0, evt_out}, {63'd0, exp_shot_out});
        for (int i = 0; i < 200 && after < 3; i++) begin
            @(negedge clk);
            if (!fired && (tod - 64'd1) >= target) begin
                fired = 1'b1;
                exp_shot_out = lvl;
            end
            if (fired) after++;
            chk(off < 0 ? "R6 late shot out" : "R5 shot out", {63'd0, evt_out}, {63'd0, exp_shot_out});
            chk("R5 shot armed", {63'd0, evt_armed}, {63'd0, !fired});
        end
    endtask

    task automatic set_halves(input int unsigned h, input int unsigned l);
        wr(3'd5, {16'd0, l[23:0], h[23:0]});
        if (h != 0 && l != 0) begin
            cur_hi = h;
            cur_lo = l;
        end
    endtask

    // clock run; start offset and length in ticks
    task automatic run_clk(input int unsigned soff, input int unsigned len, input string req);
        longint unsigned start, stop, c, s_eff;
        logic first = 1'b1;
        logic done  = 1'b0;
        logic e;
        int   after = 0;
        start = longint'(tod) + longint'(soff);
        stop  = start + longint'(len);
        s_eff = start;
        wr(3'd3, start);
        wr(3'd4, stop);
        wr(3'd6, 64'd2);
        chk("R8 low after arm", {63'd0, evt_out}, 64'd0);
        chk("R8 armed after arm", {63'd0, evt_armed}, 64'd1);
        for (int i = 0; i < 400 && after < 3; i++) begin
            @(negedge clk);
            c = longint'(tod) - 1;
            if (first) begin
                if (c > s_eff) s_eff = c;
                first = 1'b0;
            end
            if (done || c >= stop) begin
                done = 1'b1;
                e = 1'b0;
                after++;
            end else if (c >= s_eff) begin
                e = clk_expect(c, s_eff, cur_hi, cur_lo);
            end else begin
                e = 1'b0;
            end
            chk(req, {63'd0, evt_out}, {63'd0, e});
            chk("R9 armed until stop", {63'd0, evt_armed}, {63'd0, !done});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] t0;
        void'($urandom(32'd20240607));

        // R11 / R1: reset state
        repeat (3) @(negedge clk);
        chk("R11 out in reset", {63'd0, evt_out}, 64'd0);
        chk("R11 armed in reset", {63'd0, evt_armed}, 64'd0);
        chk("R11 error in reset", {63'd0, cfg_error}, 64'd0);
        chk("R1 count in reset", tod, 64'd0);
        rst_n = 1'b1;

        // R1: steady advance
        @(negedge clk);
        t0 = tod;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R1 advance", tod, t0 + 64'(i));
        end

        // R2 and R1 wrap
        wr(3'd0, 64'hFFFF_FFFF_FFFF_FFF0);
        chk("R2 load", tod, 64'hFFFF_FFFF_FFFF_FFF0);
        repeat (20) @(negedge clk);
        chk("R1 wrap", tod, 64'd4);

        // R3: signed shift, backward and forward
        wr(3'd0, 64'd5000);
        wr(3'd1, -64'd100);
        chk("R3 shift back", tod, tod_at_wr + 64'd1 - 64'd100);
        wr(3'd1, 64'd37);
        chk("R3 shift fwd", tod, tod_at_wr + 64'd38);

        // one-shots: R5, R6
        wr(3'd0, 64'd1000);
        run_shot(10, 1'b1);
        run_shot(4, 1'b0);
        run_shot(-8, 1'b1);
        for (int k = 0; k < 5; k++) begin
            int off;
            off = int'($urandom_range(40)) - 10;
            run_shot(off, 1'($urandom_range(1)));
        end

        // R7: hold after fire while count and target move
        wr(3'd2, 64'd0);
        wr(3'd0, 64'd10);
        repeat (4) @(negedge clk);
        chk("R7 hold out", {63'd0, evt_out}, {63'd0, exp_shot_out});
        chk("R7 stays disarmed", {63'd0, evt_armed}, 64'd0);

        // R10: cancelled one-shot keeps level even after target passes
        wr(3'd0, 64'd1000);
        wr(3'd2, 64'd1030);
        wr(3'd6, {61'd0, ~exp_shot_out, 2'd1});
        wr(3'd6, 64'd0);
        chk("R10 shot cancel armed", {63'd0, evt_armed}, 64'd0);
        repeat (40) @(negedge clk);
        chk("R10 shot cancel out", {63'd0, evt_out}, {63'd0, exp_shot_out});

        // R4: rejected and accepted phase writes
        set_halves(0, 3);
        chk("R4 error on zero high", {63'd0, cfg_error}, 64'd1);
        set_halves(2, 3);
        chk("R4 error cleared", {63'd0, cfg_error}, 64'd0);
        set_halves(4, 0);
        chk("R4 error on zero low", {63'd0, cfg_error}, 64'd1);
        run_clk(10, 40, "R4 old phases in force");

        // R8: directed and random clocks
        set_halves(1, 1);
        run_clk(6, 30, "R8 clock 1/1");
        set_halves(3, 2);
        run_clk(0, 25, "R8 late start");
        for (int k = 0; k < 6; k++) begin
            set_halves($urandom_range(6, 1), $urandom_range(6, 1));
            run_clk($urandom_range(25), $urandom_range(80, 1), "R8 random clock");
        end

        // R9: stop mid high phase, and stop before start
        set_halves(10, 10);
        run_clk(8, 5, "R9 stop mid high");
        wr(3'd3, tod + 64'd50);
        wr(3'd4, tod);
        wr(3'd6, 64'd2);
        repeat (2) @(negedge clk);
        chk("R9 never started armed", {63'd0, evt_armed}, 64'd0);
        chk("R9 never started out", {63'd0, evt_out}, 64'd0);

        // R10: cancel a running clock
        set_halves(8, 8);
        wr(3'd3, tod + 64'd4);
        wr(3'd4, tod + 64'd500);
        wr(3'd6, 64'd2);
        repeat (8) @(negedge clk);
        chk("R10 clock running", {63'd0, evt_out}, 64'd1);
        wr(3'd6, 64'd0);
        chk("R10 clock cancel out", {63'd0, evt_out}, 64'd0);
        chk("R10 clock cancel armed", {63'd0, evt_armed}, 64'd0);

        // R10: arming a shot cancels a clock
        wr(3'd6, 64'd2);
        wr(3'd2, tod + 64'd300);
        wr(3'd6, {61'd0, 1'b1, 2'd1});
        repeat (3) @(negedge clk);
        chk("R10 shot replaces clock armed", {63'd0, evt_armed}, 64'd1);
        chk("R10 shot replaces clock out", {63'd0, evt_out}, {63'd0, exp_shot_out});

        summary();
    end

endmodule